// File: doc/BRIEF.md
# Monitor Channel Handshake Receiver

This block is the receive side of a byte-per-frame control channel with a two-wire handshake. A remote transmitter holds an active-low transmit marker and presents one data byte in every frame. This block holds an active-low acknowledge line that it drives back. A one-cycle frame strobe tells the block when the marker and the byte are valid. On every other cycle it ignores those inputs.

A message begins when the marker goes active after the channel has been seen idle. The block takes a byte only after the same value has arrived in two frames in a row. It then pulls the acknowledge line low for a set number of frames and releases it. After the release it waits for the transmitter to announce the next byte, or to go idle to end the message.

Each accepted byte comes out with a one-cycle valid pulse. A flag marks the first byte of a message. Separate one-cycle pulses report end of message and abort. A marker that goes inactive while a byte is still unconfirmed is a protocol violation, and so is a local abort request. Either one drops all pending state. Bytes that were already delivered are kept.

Top module: `mcr_rx`

## Requirements
- R1: While reset is held and right after it, `rx_ack_n` is 1 and `rx_valid`, `rx_eom` and `rx_abort` are 0.
- R2: When idle, a frame with `tx_mark_n`=0 starts a message only if the frame before it had `tx_mark_n`=1. After reset or an abort, a marker that stays low starts nothing.
- R3: Within a message, a byte is accepted only when two consecutive frames carry `tx_mark_n`=0 and identical `chan_data`. If the value changes first, the new value becomes the candidate. On acceptance, `rx_valid` is 1 for one cycle, starting the cycle after the strobe edge, and `rx_data` holds the byte.
- R4: `rx_first` is 1 with the first accepted byte of a message and 0 with every later one.
- R5: `rx_ack_n` goes to 0 together with `rx_valid`. It stays 0 through the next `ACK_FRAMES` frame strobes (default 2) and returns to 1 at the last of them.
- R6: After the release, one frame with `tx_mark_n`=1 followed by a frame with `tx_mark_n`=0 starts the next byte. Frames with `tx_mark_n`=0 that come without that preceding high frame are repeats and have no effect.
- R7: After the release, two consecutive frames with `tx_mark_n`=1 (with `rx_ack_n`=1) give a one-cycle `rx_eom` pulse and return the block to idle.
- R8: A frame with `tx_mark_n`=1 while a byte is awaiting confirmation gives a one-cycle `rx_abort` pulse, drives `rx_ack_n` to 1 and returns the block to idle.
- R9: `abort_req`=1 in any cycle gives `rx_abort` in the next cycle, drives `rx_ack_n` to 1 and clears the candidate byte, the first-byte state and the idle history.
- R10: `rx_valid`, `rx_eom` and `rx_abort` are one-cycle pulses, and no two of them are high at once. `tx_mark_n` and `chan_data` have no effect in cycles without `frame_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_stb | input | 1 | One-cycle strobe marking a frame sample |
| tx_mark_n | input | 1 | Transmit marker from the remote side, active low |
| chan_data | input | DATA_W | Data byte of the current frame |
| abort_req | input | 1 | Local request to abort the current message |
| rx_ack_n | output | 1 | Acknowledge returned to the transmitter, active low |
| rx_data | output | DATA_W | Last accepted byte |
| rx_valid | output | 1 | One-cycle pulse per accepted byte |
| rx_first | output | 1 | Accepted byte is the first of its message |
| rx_eom | output | 1 | One-cycle end-of-message pulse |
| rx_abort | output | 1 | One-cycle abort pulse |

## Verification
The bench goes after the following corner cases:
- A marker still low after reset or an abort: a design that skipped the idle history would start a message from a stale frame.
- A byte that changes before it is confirmed: a design that kept the old candidate would accept a value that never appeared twice.
- Repeated frames during and after the acknowledge: a miscounted acknowledge timer shows up as `rx_ack_n` released one frame early or late. A design that took a repeat as a new byte would emit a duplicate.
- A marker released mid-confirmation and a local abort during the acknowledge: a design that kept `rx_ack_n` low or kept the first-byte state would misflag the next message.
- Random garbage on the marker and data between strobes: this exposes any path that samples them without the strobe.

// File: rtl/mcr_pkg.sv
// Shared types for the handshake receiver.
package mcr_pkg;

    // Receiver phases:
    //   idle    - between messages
    //   confirm - candidate byte held, waiting for an identical repeat
    //   ack     - acknowledge held low
    //   release - acknowledge high, waiting for the next byte or for idle
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_ACK     = 2'd2,
        ST_RELEASE = 2'd3
    } mcr_state_e;

endpackage

// File: rtl/mcr_cand_reg.sv
// Candidate byte register.
// Holds the byte last seen in the confirm phase and compares it with the
// incoming byte. Assumes load and clr are asserted only on frame or abort
// decisions made by the controller; clr wins over load.
module mcr_cand_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              clr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] cand,
    output logic              match
);

    // Capture or clear the candidate value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cand <= '0;
        end else if (load) begin
            cand <= din;
        end
    end

    // Incoming byte equals the held candidate.
    always_comb begin
        match = (din == cand);
    end

endmodule

// File: rtl/mcr_ack_timer.sv
// Acknowledge frame counter.
// Loaded with the hold length when a byte is accepted. It counts down once
// per frame strobe, and `done` flags the strobe that ends the hold.
// Assumes start never coincides with a running count.
module mcr_ack_timer #(
    parameter int FRAMES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    input  logic clr,
    output logic done
);

    localparam int LEN = (FRAMES < 1) ? 1 : FRAMES;
    localparam int CW  = $clog2(LEN + 1);

    logic [CW-1:0] cnt_q;

    // Load, count down per frame, or clear on abort.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CW'(LEN);
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Final frame of the hold.
    always_comb begin
        done = tick && (cnt_q == CW'(1));
    end

endmodule

// File: rtl/mcr_idle_cnt.sv
// Consecutive-inactive-frame counter.
// Counts frames whose marker is inactive (high) and saturates at two. Any
// active frame resets it to zero. The controller reads the count before
// the current frame is added. clr wins over the frame update.
module mcr_idle_cnt (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic mark_hi,
    input  logic clr,
    output logic seen_hi,
    output logic one_hi
);

    logic [1:0] hi_q;

    // Track the run of inactive frames.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            hi_q <= 2'd0;
        end else if (tick) begin
            if (!mark_hi) begin
                hi_q <= 2'd0;
            end else if (hi_q != 2'd2) begin
                hi_q <= hi_q + 2'd1;
            end
        end
    end

    // Decode the count for the controller.
    always_comb begin
        seen_hi = (hi_q != 2'd0);
        one_hi  = (hi_q == 2'd1);
    end

endmodule

// File: rtl/mcr_rx.sv
// Handshake receiver top.
// Samples the transmit marker and the data byte on each frame strobe. A
// byte is confirmed across two frames and then acknowledged by holding
// rx_ack_n low for ACK_FRAMES frames. End of message and aborts are
// reported with one-cycle pulses. Assumes frame_stb is a one-cycle pulse
// and that tx_mark_n and chan_data are stable in the strobe cycle.
module mcr_rx
    import mcr_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int ACK_FRAMES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stb,
    input  logic              tx_mark_n,
    input  logic [DATA_W-1:0] chan_data,
    input  logic              abort_req,
    output logic              rx_ack_n,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_first,
    output logic              rx_eom,
    output logic              rx_abort
);

    mcr_state_e        state_q, state_d;
    logic [DATA_W-1:0] cand;
    logic              cand_match;
    logic              cand_load, cand_clr;
    logic              ack_start, ack_clr, ack_done;
    logic              hi_clr, seen_hi, one_hi;
    logic              accept, eom_d, abort_d;
    logic              ack_low, ack_rel;
    logic              first_set, first_clr, first_pend_q;

    mcr_cand_reg #(.DATA_W(DATA_W)) u_cand (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cand_load),
        .clr   (cand_clr),
        .din   (chan_data),
        .cand  (cand),
        .match (cand_match)
    );

    mcr_ack_timer #(.FRAMES(ACK_FRAMES)) u_ack (
        .clk   (clk),
        .rst_n (rst_n),
        .start (ack_start),
        .tick  (frame_stb),
        .clr   (ack_clr),
        .done  (ack_done)
    );

    mcr_idle_cnt u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (frame_stb),
        .mark_hi (tx_mark_n),
        .clr     (hi_clr),
        .seen_hi (seen_hi),
        .one_hi  (one_hi)
    );

    // Per-frame protocol decisions and the next phase.
    always_comb begin
        state_d   = state_q;
        cand_load = 1'b0;
        cand_clr  = 1'b0;
        ack_start = 1'b0;
        ack_clr   = 1'b0;
        hi_clr    = 1'b0;
        accept    = 1'b0;
        eom_d     = 1'b0;
        abort_d   = 1'b0;
        ack_low   = 1'b0;
        ack_rel   = 1'b0;
        first_set = 1'b0;
        first_clr = 1'b0;
        if (abort_req) begin
            abort_d   = 1'b1;
        end else if (frame_stb) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (!tx_mark_n && seen_hi) begin
                        cand_load = 1'b1;
                        first_set = 1'b1;
                        state_d   = ST_CONFIRM;
                    end
                end
                ST_CONFIRM: begin
                    if (tx_mark_n) begin
                        abort_d = 1'b1;
                    end else if (cand_match) begin
                        accept    = 1'b1;
                        first_clr = 1'b1;
                        ack_low   = 1'b1;
                        ack_start = 1'b1;
                        state_d   = ST_ACK;
                    end else begin
                        cand_load = 1'b1;
                    end
                end
                ST_ACK: begin
                    if (ack_done) begin
                        ack_rel = 1'b1;
                        hi_clr  = 1'b1;
                        state_d = ST_RELEASE;
                    end
                end
                ST_RELEASE: begin
                    if (tx_mark_n) begin
                        if (one_hi) begin
                            eom_d   = 1'b1;
                            state_d = ST_IDLE;
                        end
                    end else if (one_hi) begin
                        cand_load = 1'b1;
                        state_d   = ST_CONFIRM;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
        if (abort_d) begin
            state_d   = ST_IDLE;
            cand_load = 1'b0;
            cand_clr  = 1'b1;
            ack_clr   = 1'b1;
            hi_clr    = 1'b1;
            ack_rel   = 1'b1;
            first_clr = 1'b1;
        end
    end

    // Phase, output pulses, delivered byte and acknowledge level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            rx_ack_n     <= 1'b1;
            rx_data      <= '0;
            rx_valid     <= 1'b0;
            rx_first     <= 1'b0;
            rx_eom       <= 1'b0;
            rx_abort     <= 1'b0;
            first_pend_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            rx_valid <= accept;
            rx_eom   <= eom_d;
            rx_abort <= abort_d;
            if (accept) begin
                rx_data  <= cand;
                rx_first <= first_pend_q;
            end
            if (ack_low) begin
                rx_ack_n <= 1'b0;
            end else if (ack_rel) begin
                rx_ack_n <= 1'b1;
            end
            if (first_set) begin
                first_pend_q <= 1'b1;
            end else if (first_clr) begin
                first_pend_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/mcr_rx_chk.sv
// Protocol checker for mcr_rx, attached by bind. Observes ports only.
module mcr_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_stb,
    input logic              tx_mark_n,
    input logic [DATA_W-1:0] chan_data,
    input logic              abort_req,
    input logic              rx_ack_n,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_valid,
    input logic              rx_first,
    input logic              rx_eom,
    input logic              rx_abort
);

    // R10: the three event pulses never overlap.
    p_pulses_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rx_valid, rx_eom, rx_abort}) <= 1);

    // R10: the valid pulse lasts one cycle.
    p_valid_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R3: acceptance only follows a frame strobe.
    p_valid_after_stb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(frame_stb));

    // R5: the acknowledge is low together with the valid pulse.
    p_ack_with_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !rx_ack_n);

    // R5: once low, the acknowledge holds until a strobe or an abort.
    p_ack_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_ack_n) && !frame_stb && !abort_req |=> !rx_ack_n);

    // R7: end of message comes from an inactive-marker frame with acknowledge high.
    p_eom_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_eom |-> rx_ack_n && $past(rx_ack_n) && $past(frame_stb) && $past(tx_mark_n));

    // R9: a local abort request is reported in the next cycle.
    p_abort_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |=> rx_abort);

    // R8: an abort always leaves the acknowledge released.
    p_abort_rel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_abort |-> rx_ack_n);

endmodule

bind mcr_rx mcr_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_stb (frame_stb),
    .tx_mark_n (tx_mark_n),
    .chan_data (chan_data),
    .abort_req (abort_req),
    .rx_ack_n  (rx_ack_n),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid),
    .rx_first  (rx_first),
    .rx_eom    (rx_eom),
    .rx_abort  (rx_abort)
);

// File: tb/sim_mcr_rx.sv
// Bench for mcr_rx: directed corner cases, then seeded random frames,
// checked against a frame-level model written from the requirements.
module sim_mcr_rx;

    localparam int DW  = 8;
    localparam int ACK = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_stb = 1'b0;
    logic          tx_mark_n = 1'b1;
    logic [DW-1:0] chan_data = '0;
    logic          abort_req = 1'b0;
    logic          rx_ack_n, rx_valid, rx_first, rx_eom, rx_abort;
    logic [DW-1:0] rx_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Frame-level expectation state.
    int            m_st = 0;   // 0 idle, 1 confirm, 2 ack, 3 release
    int            m_hi = 0;
    logic [DW-1:0] m_cand = '0;
    bit            m_first = 1'b0;
    int            m_ack = 0;
    logic          m_mr = 1'b1;
    logic          e_v, e_f, e_eom, e_ab;
    logic [DW-1:0] e_d;

    mcr_rx #(.DATA_W(DW), .ACK_FRAMES(ACK)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .tx_mark_n(tx_mark_n),
        .chan_data(chan_data), .abort_req(abort_req), .rx_ack_n(rx_ack_n),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_first(rx_first),
        .rx_eom(rx_eom), .rx_abort(rx_abort)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Advance the model by one frame.
    task automatic model_frame(input logic mk, input logic [DW-1:0] d);
        int hb;
        hb = m_hi;
        e_v = 0; e_eom = 0; e_ab = 0; e_f = 0; e_d = '0;
        m_hi = mk ? ((m_hi == 2) ? 2 : m_hi + 1) : 0;
        case (m_st)
            0: if (!mk && hb != 0) begin m_cand = d; m_first = 1; m_st = 1; end
            1: if (mk) begin
                   e_ab = 1; m_st = 0; m_mr = 1; m_hi = 0; m_first = 0; m_cand = '0;
               end else if (d == m_cand) begin
                   e_v = 1; e_d = d; e_f = m_first; m_first = 0; m_mr = 0; m_ack = ACK; m_st = 2;
               end else m_cand = d;
            2: begin
                   m_ack--;
                   if (m_ack == 0) begin m_mr = 1; m_hi = 0; m_st = 3; end
               end
            default: if (mk) begin
                   if (hb == 1) begin e_eom = 1; m_st = 0; end
               end else if (hb == 1) begin m_cand = d; m_st = 1; end
        endcase
    endtask

    // Drive one frame, check its result, then check quiet gap cycles with garbage inputs.
    task automatic frame(input logic mk, input logic [DW-1:0] d);
        @(negedge clk);
        frame_stb = 1; tx_mark_n = mk; chan_data = d;
        @(negedge clk);
        frame_stb = 0; tx_mark_n = 1'($urandom); chan_data = DW'($urandom);
        model_frame(mk, d);
        chk("R3 valid", rx_valid, e_v);
        if (e_v) begin
            chk("R3 data", rx_data, e_d);
            chk("R4 first", rx_first, e_f);
        end
        chk("R7 eom", rx_eom, e_eom);
        chk("R8 abort", rx_abort, e_ab);
        chk("R5 ack level", rx_ack_n, m_mr);
        repeat (2) begin
            @(negedge clk);
            chk("R10 no pulse between strobes", {rx_valid, rx_eom, rx_abort}, 0);
            chk("R10 ack stable between strobes", rx_ack_n, m_mr);
        end
    endtask

    task automatic local_abort();
        @(negedge clk);
        abort_req = 1;
        @(negedge clk);
        abort_req = 0;
        chk("R9 abort pulse", rx_abort, 1);
        chk("R9 ack released", rx_ack_n, 1);
        m_st = 0; m_mr = 1; m_hi = 0; m_first = 0; m_ack = 0; m_cand = '0;
        @(negedge clk);
        chk("R10 abort single", rx_abort, 0);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7331));
        repeat (3) @(negedge clk);
        chk("R1 ack in reset", rx_ack_n, 1);
        chk("R1 pulses in reset", {rx_valid, rx_eom, rx_abort}, 0);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        chk("R1 ack after reset", rx_ack_n, 1);
        chk("R1 pulses after reset", {rx_valid, rx_eom, rx_abort}, 0);

        // R2: marker low with no idle history starts nothing.
        frame(0, 8'h55); frame(0, 8'h55);
        chk("R2 no start without idle frame", rx_valid, 0);
        // Idle frame, then a first byte with an unstable value.
        frame(1, 8'h00);
        frame(0, 8'h11); frame(0, 8'h22); frame(0, 8'h22);
        chk("R3 stable value accepted", rx_data, 8'h22);
        frame(0, 8'h22); frame(0, 8'h22);           // R5 acknowledge frames
        frame(0, 8'h22); frame(0, 8'h22);           // R6 repeats ignored
        chk("R6 repeat gives no byte", rx_valid, 0);
        frame(1, 8'h00); frame(0, 8'h22); frame(0, 8'h22);  // identical next byte
        chk("R4 later byte not first", rx_first, 0);
        frame(0, 8'h22); frame(0, 8'h22);
        frame(1, 8'h00); frame(1, 8'h00);           // R7 end of message
        // R8: marker released during confirmation.
        frame(0, 8'h5A); frame(1, 8'h5A);
        // R9: local abort during the acknowledge, then a low marker must not restart.
        frame(1, 8'h00); frame(0, 8'h66); frame(0, 8'h66);
        local_abort();
        frame(0, 8'h77); frame(0, 8'h77);
        chk("R9 no restart without idle frame", rx_valid, 0);
        frame(1, 8'h00); frame(0, 8'h77); frame(0, 8'h77);
        chk("R4 first after abort", rx_first, 1);

        // Seeded random frames.
        for (int i = 0; i < 800; i++) begin
            logic mk;
            logic [DW-1:0] d;
            int pick;
            mk = ($urandom_range(0, 9) < 3);
            pick = $urandom_range(0, 3);
            d = (pick < 2) ? 8'h3C : ((pick == 2) ? 8'hA5 : DW'($urandom));
            frame(mk, d);
            if ($urandom_range(0, 59) == 0) local_abort();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule